// File: doc/BRIEF.md
# Walking-Bit Register Self-Test Sequencer

This block is a built-in self-test controller for a small register file, for example the translation table of a memory-management unit. The register file has 8-bit addresses and 12-bit words. After a start request the sequencer runs a fixed walking-ones schedule of twelve write-then-readback steps. The schedule toggles every address bit and every data bit at least once. Each readback is compared with the word just written.

If the pass is clean, the sequencer raises a pass flag and returns to idle. If any readback differs, or if an external address-fault input is seen during the pass, the sequencer enters a diagnostic loop that it never leaves. Each iteration first signals the fault class as active-low reset pulses: two pulses for an address fault and one for a data fault. It then replays the full schedule, so that a probe on the register file's write strobe can catch the failing bit. A companion halt output is never asserted, so the pulses reset only the surrounding logic.

Top module: `regtest_seq`

## Requirements
- R1: While reset is held and just after it, the reset-pulse output and the halt output are high, and the pass, fail, busy, write-strobe and read-strobe outputs are low.
- R2: A start request in idle begins a pass whose first seven writes go to addresses 0x02, 0x04, 0x08, 0x10, 0x20, 0x40 and 0x80, carrying 0x001, 0x002, 0x004, 0x008, 0x010, 0x020 and 0x040 respectively.
- R3: The remaining five writes of a pass go to 0x03, 0x05, 0x09, 0x11 and 0x21, carrying 0x080, 0x100, 0x200, 0x400 and 0x800 respectively.
- R4: Every write strobe lasts one cycle and is followed in the next cycle by a one-cycle read strobe at the same address. Read data is taken one cycle after the read strobe, so each step takes three cycles.
- R5: On a clean pass, the pass flag rises exactly 36 cycles after the start is accepted, busy falls in the same cycle, and the reset-pulse output never goes low.
- R6: Any fault detected by the end of a pass raises the fail flag. The sequencer then stays in the diagnostic loop, and start requests no longer have any effect.
- R7: A data fault (readback differs from the written word) produces, in each loop iteration, a single low pulse of PULSE_LOW cycles, and iterations repeat every PULSE_PERIOD cycles.
- R8: An address-fault input seen while busy produces two low pulses of PULSE_LOW cycles each, separated by PULSE_LOW high cycles, every PULSE_PERIOD cycles. This class wins when both faults are present. The input is ignored while idle.
- R9: After its pulses, each loop iteration replays all twelve steps in schedule order before the next iteration begins.
- R10: The halt output is never driven low, including during reset pulses.
- R11: A start request while a pass is running is ignored. The pass keeps its timing and performs exactly twelve writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one test pass (idle only) |
| addr_fault_i | input | 1 | External address-fault indication, sampled while busy |
| rf_rdata_i | input | 12 | Register-file read data, valid one cycle after the read strobe |
| rf_addr_o | output | 8 | Register-file address |
| rf_wdata_o | output | 12 | Register-file write data |
| rf_we_o | output | 1 | Write strobe, one cycle |
| rf_re_o | output | 1 | Read strobe, one cycle |
| busy_o | output | 1 | A pass or the diagnostic loop is active |
| pass_o | output | 1 | Last pass was clean |
| fail_o | output | 1 | Fault found; diagnostic loop active |
| rst_pulse_n_o | output | 1 | Active-low coded fault pulses |
| halt_n_o | output | 1 | Active-low halt, held inactive |

## Verification
A wrong step counter or pattern decode shows up within one three-cycle step as an unexpected address or word on the write port. A broken strobe sequence shows within a cycle as a read strobe that does not follow a write to the same address. A wrongly latched fault class shows at the first loop iteration as the wrong pulse count. Pulse spacing is measured edge to edge, so a period counter that is off by one appears after one PULSE_PERIOD. A sequencer that misses a mismatch reports pass at cycle 36 where fail was due.

// File: rtl/regtest_pkg.sv
package regtest_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_CMP,
    ST_EWAIT
  } seq_st_t;
endpackage

// File: rtl/rt_pattern.sv
// Walking-ones schedule decode: step i writes data bit i.
// First AW-1 steps walk a single address bit upward from bit 1;
// later steps keep bit 0 set and walk a second bit from bit 1.
module rt_pattern #(
  parameter int AW = 8,
  parameter int DW = 12,
  parameter int SW = $clog2(DW)
) (
  input  logic [SW-1:0] step_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  localparam int PH1 = AW - 1;

  always_comb begin
    int idx;
    idx    = int'(step_i);
    data_o = DW'(1) << idx;
    if (idx < PH1) addr_o = AW'(1) << (idx + 1);
    else           addr_o = AW'(1) | (AW'(1) << (idx - PH1 + 1));
  end
endmodule

// File: rtl/rt_err_track.sv
module rt_err_track #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          cmp_en_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [DW-1:0] expect_i,
  input  logic          afault_i,
  output logic          any_err_nxt_o,
  output logic          two_pulse_o
);
  logic data_q, addr_q, data_d, addr_d;

  always_comb begin
    data_d = data_q | (cmp_en_i && (rdata_i != expect_i));
    addr_d = addr_q | afault_i;
    if (clr_i) begin
      data_d = 1'b0;
      addr_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= 1'b0;
      addr_q <= 1'b0;
    end else begin
      data_q <= data_d;
      addr_q <= addr_d;
    end
  end

  assign any_err_nxt_o = data_d | addr_d;
  assign two_pulse_o   = addr_q;  // address class takes priority
endmodule

// File: rtl/rt_pulse.sv
module rt_pulse #(
  parameter int PULSE_LOW    = 1250,
  parameter int PULSE_PERIOD = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic two_i,
  output logic go_pass_o,
  output logic pulse_n_o
);
  localparam int CW = $clog2(PULSE_PERIOD + 1);

  logic [CW-1:0] cnt;
  logic          two_q, two_e, low;
  int            c;

  always_ff @(posedge clk) begin
    if (rst || !en_i) cnt <= '0;
    else if (int'(cnt) == PULSE_PERIOD - 1) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) two_q <= 1'b0;
    else if (en_i && cnt == '0) two_q <= two_i;
  end

  always_comb begin
    c     = int'(cnt);
    two_e = (cnt == '0) ? two_i : two_q;
    low   = (c < PULSE_LOW) ||
            (two_e && c >= 2 * PULSE_LOW && c < 3 * PULSE_LOW);
    go_pass_o = en_i && (c == (two_e ? 3 * PULSE_LOW : PULSE_LOW));
  end

  always_ff @(posedge clk) begin
    if (rst) pulse_n_o <= 1'b1;
    else     pulse_n_o <= !(en_i && low);
  end
endmodule

// File: rtl/regtest_seq.sv
module regtest_seq #(
  parameter int AW           = 8,
  parameter int DW           = 12,
  parameter int PULSE_LOW    = 1250,
  parameter int PULSE_PERIOD = 10000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          addr_fault_i,
  input  logic [DW-1:0] rf_rdata_i,
  output logic [AW-1:0] rf_addr_o,
  output logic [DW-1:0] rf_wdata_o,
  output logic          rf_we_o,
  output logic          rf_re_o,
  output logic          busy_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic          rst_pulse_n_o,
  output logic          halt_n_o
);
  import regtest_pkg::*;

  localparam int SW = $clog2(DW);

  seq_st_t       st, st_n;
  logic [SW-1:0] step, step_n;
  logic          load, pass_set, emode_set, accept;
  logic          err_mode;
  logic          any_err_nxt, two_pulse, go_pass;
  logic [AW-1:0] pat_addr;
  logic [DW-1:0] pat_data;

  rt_pattern #(.AW(AW), .DW(DW), .SW(SW)) u_pat (
    .step_i (step_n),
    .addr_o (pat_addr),
    .data_o (pat_data)
  );

  rt_err_track #(.DW(DW)) u_err (
    .clk           (clk),
    .rst           (rst),
    .clr_i         (accept),
    .cmp_en_i      (st == ST_CMP),
    .rdata_i       (rf_rdata_i),
    .expect_i      (rf_wdata_o),
    .afault_i      (addr_fault_i && st != ST_IDLE),
    .any_err_nxt_o (any_err_nxt),
    .two_pulse_o   (two_pulse)
  );

  rt_pulse #(.PULSE_LOW(PULSE_LOW), .PULSE_PERIOD(PULSE_PERIOD)) u_pulse (
    .clk       (clk),
    .rst       (rst),
    .en_i      (err_mode),
    .two_i     (two_pulse),
    .go_pass_o (go_pass),
    .pulse_n_o (rst_pulse_n_o)
  );

  always_comb begin
    st_n      = st;
    step_n    = step;
    load      = 1'b0;
    accept    = 1'b0;
    pass_set  = 1'b0;
    emode_set = 1'b0;
    unique case (st)
      ST_IDLE: if (start_i) begin
        st_n   = ST_WR;
        step_n = '0;
        load   = 1'b1;
        accept = 1'b1;
      end
      ST_WR:  st_n = ST_RD;
      ST_RD:  st_n = ST_CMP;
      ST_CMP: begin
        if (int'(step) == DW - 1) begin
          if (err_mode || any_err_nxt) begin
            st_n      = ST_EWAIT;
            emode_set = 1'b1;
          end else begin
            st_n     = ST_IDLE;
            pass_set = 1'b1;
          end
        end else begin
          st_n   = ST_WR;
          step_n = step + 1'b1;
          load   = 1'b1;
        end
      end
      ST_EWAIT: if (go_pass) begin
        st_n   = ST_WR;
        step_n = '0;
        load   = 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      step       <= '0;
      rf_addr_o  <= '0;
      rf_wdata_o <= '0;
      rf_we_o    <= 1'b0;
      rf_re_o    <= 1'b0;
      pass_o     <= 1'b0;
      err_mode   <= 1'b0;
      halt_n_o   <= 1'b1;
    end else begin
      st       <= st_n;
      step     <= step_n;
      rf_we_o  <= load;
      rf_re_o  <= (st_n == ST_RD);
      halt_n_o <= 1'b1;
      if (load) begin
        rf_addr_o  <= pat_addr;
        rf_wdata_o <= pat_data;
      end
      if (accept)        pass_o <= 1'b0;
      else if (pass_set) pass_o <= 1'b1;
      if (emode_set) err_mode <= 1'b1;
    end
  end

  assign busy_o = (st != ST_IDLE);
  assign fail_o = err_mode;
endmodule

// File: rtl/regtest_chk.sv
module regtest_chk #(
  parameter int AW        = 8,
  parameter int PULSE_LOW = 1250
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] rf_addr_o,
  input logic          rf_we_o,
  input logic          rf_re_o,
  input logic          pass_o,
  input logic          fail_o,
  input logic          rst_pulse_n_o
);
  logic [31:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || rst_pulse_n_o) low_run <= '0;
    else                      low_run <= low_run + 1'b1;
  end

  // R4: write and read strobes never overlap
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(rf_we_o && rf_re_o));
  // R4: a write is followed by a read at the same address
  p_read_follows_r4: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |=> (rf_re_o && $stable(rf_addr_o)));
  // R4: read strobe lasts one cycle
  p_read_single_r4: assert property (@(posedge clk) disable iff (rst)
    rf_re_o |=> !rf_re_o);
  // R5: pass and fail never together
  p_pass_fail_r5: assert property (@(posedge clk) disable iff (rst)
    !(pass_o && fail_o));
  // R5: no reset pulse without a fault
  p_no_pulse_clean_r5: assert property (@(posedge clk) disable iff (rst)
    !fail_o |-> rst_pulse_n_o);
  // R6: fail is sticky
  p_fail_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    fail_o |=> fail_o);
  // R7: a low pulse never exceeds its width
  p_pulse_width_r7: assert property (@(posedge clk) disable iff (rst)
    low_run <= 32'(PULSE_LOW));
endmodule

bind regtest_seq regtest_chk #(.AW(AW), .PULSE_LOW(PULSE_LOW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .rf_addr_o     (rf_addr_o),
  .rf_we_o       (rf_we_o),
  .rf_re_o       (rf_re_o),
  .pass_o        (pass_o),
  .fail_o        (fail_o),
  .rst_pulse_n_o (rst_pulse_n_o)
);

// File: tb/tb_regtest_seq.sv
`timescale 1ns/1ps
module tb_regtest_seq;
  localparam int AW = 8, DW = 12, LOW = 4, PER = 64;

  // expected schedule: {address, data}
  localparam logic [19:0] SCHED [12] = '{
    {8'h02, 12'h001}, {8'h04, 12'h002}, {8'h08, 12'h004}, {8'h10, 12'h008},
    {8'h20, 12'h010}, {8'h40, 12'h020}, {8'h80, 12'h040},
    {8'h03, 12'h080}, {8'h05, 12'h100}, {8'h09, 12'h200}, {8'h11, 12'h400},
    {8'h21, 12'h800}};

  logic clk = 0, rst = 1, start = 0, afault = 0;
  logic [DW-1:0] rdata;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic we, re, busy, pass, fail, rpn, haltn;

  regtest_seq #(.AW(AW), .DW(DW), .PULSE_LOW(LOW), .PULSE_PERIOD(PER)) dut (
    .clk(clk), .rst(rst), .start_i(start), .addr_fault_i(afault),
    .rf_rdata_i(rdata), .rf_addr_o(addr), .rf_wdata_o(wdata),
    .rf_we_o(we), .rf_re_o(re), .busy_o(busy), .pass_o(pass),
    .fail_o(fail), .rst_pulse_n_o(rpn), .halt_n_o(haltn));

  always #10 clk = ~clk;

  // register file model with a bit-flip fault
  logic [DW-1:0] mem [256];
  logic [AW-1:0] f_addr = '0;
  logic [DW-1:0] f_mask = '0;
  always @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr] ^ ((addr == f_addr) ? f_mask : '0);
  end

  int checks = 0, failures = 0, cyc = 0;
  int wr_n, rd_bad, halt_low, fall_n, wid_n;
  int wr_t [64]; logic [19:0] wr_v [64];
  int fall_t [8]; int wid [8];
  logic prev_we, prev_rpn; logic [AW-1:0] last_wa; int low_start;

  task automatic clear_logs();
    wr_n = 0; rd_bad = 0; fall_n = 0; wid_n = 0; halt_low = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!haltn) halt_low++;
    if (we) begin
      if (wr_n < 64) begin wr_t[wr_n] = cyc; wr_v[wr_n] = {addr, wdata}; end
      wr_n++; last_wa = addr;
      if (re) rd_bad++;
    end
    if (re && (!prev_we || addr != last_wa)) rd_bad++;
    if (prev_rpn && !rpn) begin
      if (fall_n < 8) fall_t[fall_n] = cyc;
      fall_n++; low_start = cyc;
    end
    if (!prev_rpn && rpn) begin
      if (wid_n < 8) wid[wid_n] = cyc - low_start;
      wid_n++;
    end
    prev_we = we; prev_rpn = rpn;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; start = 0; afault = 0;
    repeat (3) @(negedge clk);
    rst = 0; clear_logs(); prev_we = 0; prev_rpn = 1;
  endtask

  task automatic wait_falls(input int n);
    int t = 0;
    while (fall_n < n && t < 2000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic check_sched(input string req, input int base, input int lo, input int hi);
    for (int i = lo; i < hi; i++) begin
      chk(req, int'(wr_v[base + i][19:12]), int'(SCHED[i][19:12]));
      chk(req, int'(wr_v[base + i][11:0]), int'(SCHED[i][11:0]));
    end
  endtask

  initial begin
    int t;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    rst = 1;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 rst_pulse_n", int'(rpn), 1);
    chk("R1 halt_n", int'(haltn), 1);
    chk("R1 pass/fail", int'({pass, fail}), 0);
    chk("R1 busy/we/re", int'({busy, we, re}), 0);
    do_reset();
    chk("R1 after release", int'({pass, fail, busy, we, re}), 0);

    // R8: address fault while idle is ignored; then clean pass (R2 R3 R5 R11)
    afault = 1; @(negedge clk); afault = 0;
    start = 1; @(negedge clk); start = 0;
    t = 1;
    while (!pass && t < 200) begin
      @(negedge clk); t++;
      if (t == 10) start = 1;         // R11: ignored while busy
      if (t == 11) start = 0;
    end
    chk("R5 pass latency", t, 37);
    chk("R5 busy low", int'(busy), 0);
    chk("R8 idle fault ignored", int'(fail), 0);
    repeat (5) @(negedge clk);
    chk("R11 write count", wr_n, 12);
    check_sched("R2", 0, 0, 7);
    check_sched("R3", 0, 7, 12);
    chk("R4 strobe order", rd_bad, 0);
    for (int i = 1; i < 12; i++) chk("R4 step spacing", wr_t[i] - wr_t[i-1], 3);
    chk("R5 no pulse", fall_n, 0);

    // data fault at 0x10, bit 3 (R6 R7 R9)
    do_reset(); f_addr = 8'h10; f_mask = 12'h008;
    start = 1; @(negedge clk); start = 0;
    wait_falls(2);
    chk("R6 fail", int'(fail), 1);
    chk("R6 pass low", int'(pass), 0);
    start = 1; @(negedge clk); start = 0;  // R6: ignored in loop
    wait_falls(4);
    chk("R6 still busy", int'({busy, fail}), 3);
    chk("R7 width0", wid[0], LOW);
    chk("R7 width1", wid[1], LOW);
    chk("R7 period", fall_t[1] - fall_t[0], PER);
    chk("R7 period after start", fall_t[3] - fall_t[2], PER);
    begin
      int first = -1, cnt = 0;
      for (int i = 0; i < 64 && i < wr_n; i++)
        if (wr_t[i] > fall_t[0] && wr_t[i] < fall_t[1]) begin
          if (first < 0) first = i;
          cnt++;
        end
      chk("R9 writes per iteration", cnt, 12);
      if (first >= 0) check_sched("R9", first, 0, 12);
    end
    chk("R4 strobe order in loop", rd_bad, 0);
    f_mask = '0;

    // address fault only (R8)
    do_reset();
    start = 1; @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
    afault = 1; @(negedge clk); afault = 0;
    wait_falls(3);
    chk("R8 fail", int'(fail), 1);
    chk("R8 pair spacing", fall_t[1] - fall_t[0], 2 * LOW);
    chk("R8 widths", wid[0] + wid[1], 2 * LOW);
    chk("R8 period", fall_t[2] - fall_t[0], PER);

    // both faults: address class wins (R8)
    do_reset(); f_addr = 8'h05; f_mask = 12'h100;
    start = 1; @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    afault = 1; @(negedge clk); afault = 0;
    wait_falls(3);
    chk("R8 priority spacing", fall_t[1] - fall_t[0], 2 * LOW);
    chk("R8 priority period", fall_t[2] - fall_t[0], PER);
    chk("R10 halt never low", halt_low, 0);
    chk("R10 halt now", int'(haltn), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule